// File: doc/BRIEF.md
# Local Memory Access Arbiter

This block shares one single-ported local memory, which holds both code and data, among three kinds of traffic: DMA transfers, processor loads and stores, and instruction prefetch. Each cycle it picks at most one requester and drives the memory port with that requester's address, write enable and write data. The memory is 256 KB, seen as 16384 lines of 128 bits, and no cache sits in front of it.

DMA traffic is deliberately held back so that processor timing stays predictable. A free-running slot counter opens one DMA window in every eight cycles, and DMA may use the memory only in that window. DMA writes arrive as 32-bit words. They are gathered in a one-line staging buffer, so each DMA write slot moves a full line. Outside the DMA window, loads and stores take priority over prefetch. A DMA window with no DMA work pending is not wasted: it goes to the processor side.

After each branch, the prefetch sequencer reads enough consecutive lines, starting at the branch target, to cover at least 17 instructions. A later branch restarts the run at the new target.

Top module: `locmem_arbiter`

## Requirements
- R1: At most one of the DMA-write, DMA-read, load/store and prefetch grants is active in any cycle. `mem_en` is high exactly when one of them is active. The memory port carries the granted requester's fields: a DMA write drives `mem_we`=1 with the staged line address and data. A DMA read drives `mem_we`=0 with `dma_rd_addr`. Load/store drives `ls_we`, `ls_addr` and `ls_wdata`. Prefetch drives `mem_we`=0 with its current line address.
- R2: A slot counter is 0 in the first cycle after reset and advances once per cycle, modulo SLOT_PERIOD (8). A DMA read or DMA write is granted only in cycles where the counter is 0, so two DMA grants are always at least 8 cycles apart.
- R3: In a DMA window, a full staging buffer is written first. Otherwise a pending `dma_rd_req` is granted. Either one beats load/store and prefetch in that window. A DMA read held high through a window taken by a write is granted in the next window.
- R4: When no DMA request is granted in a cycle, `ls_req` wins over a pending prefetch. A DMA window with no DMA work goes to load/store, or to prefetch if no load/store is requested.
- R5: A requester left unserved stays pending until it is granted. Whenever `ls_req` is high, `mem_en` is high.
- R6: `dma_wr_ready` is high while the staging buffer holds fewer than 4 words. An accepted word number k (k = 0..3) lands in bits [32k+31:32k] of the line. The line address is captured with word 0. A word offered while `dma_wr_ready` is low is ignored. `dma_wr_ready` is high again in the cycle after the line is written.
- R7: `pf_target` is an instruction address: bits [1:0] give the instruction within a line and the upper bits give the line. A `pf_branch` pulse loads a run of ceil((offset+17)/4) lines starting at the target line. Each prefetch grant reads the next line upward. `pf_busy` is high while lines remain. A new branch restarts the run.
- R8: After reset with no requests, no grant is active, `mem_en` is 0, `dma_wr_ready` is 1 and `pf_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_rd_req | input | 1 | DMA line read request, held until granted |
| dma_rd_addr | input | 14 | DMA read line address |
| dma_rd_gnt | output | 1 | DMA read granted this cycle |
| dma_wr_valid | input | 1 | DMA write word offered |
| dma_wr_line | input | 14 | DMA write line address, taken with word 0 |
| dma_wr_word | input | 32 | DMA write data word |
| dma_wr_ready | output | 1 | Staging buffer accepts a word |
| ls_req | input | 1 | Load/store request |
| ls_we | input | 1 | Load/store write enable |
| ls_addr | input | 14 | Load/store line address |
| ls_wdata | input | 128 | Load/store write data |
| ls_gnt | output | 1 | Load/store granted |
| pf_branch | input | 1 | Branch pulse that starts a prefetch run |
| pf_target | input | 16 | Branch target instruction address |
| pf_gnt | output | 1 | Prefetch line read granted |
| pf_busy | output | 1 | Prefetch lines remain in the current run |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 14 | Memory line address |
| mem_wdata | output | 128 | Memory write data |

## Verification
The arbitration is combinational on top of three small state holders. A corrupted slot counter shows up at once as a DMA grant in the wrong cycle. The bench compares every cycle against its own phase count, so the fault is seen within eight cycles. A wrong word count or lane store in the staging buffer appears as a wrong `dma_wr_ready` within a cycle, or as a misplaced word on `mem_wdata` in the next DMA window. A bad prefetch pointer or line count appears on `mem_addr` at the first prefetch grant, or as `pf_busy` dropping at the wrong time.

// File: rtl/locmem_pkg.sv
package locmem_pkg;
   typedef enum logic [2:0] {
      GNT_NONE   = 3'd0,
      GNT_DMA_WR = 3'd1,
      GNT_DMA_RD = 3'd2,
      GNT_LS     = 3'd3,
      GNT_PF     = 3'd4
   } gnt_e;
endpackage

// File: rtl/locmem_slot_timer.sv
module locmem_slot_timer #(
   parameter int SLOT_PERIOD = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic slot_open
);
   localparam int CW = (SLOT_PERIOD > 1) ? $clog2(SLOT_PERIOD) : 1;

   if (SLOT_PERIOD < 2 || (SLOT_PERIOD & (SLOT_PERIOD - 1)) != 0) begin : g_bad_period
      $error("SLOT_PERIOD must be a power of two of at least 2");
   end

   logic [CW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_q + 1'b1;
   end

   assign slot_open = (phase_q == '0);
endmodule

// File: rtl/locmem_dma_accum.sv
module locmem_dma_accum #(
   parameter int ADDR_W = 14,
   parameter int LINE_W = 128,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_line,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              flush,
   output logic              wr_ready,
   output logic              line_full,
   output logic [ADDR_W-1:0] line_addr,
   output logic [LINE_W-1:0] line_data
);
   localparam int LANES = LINE_W / WORD_W;
   localparam int WCW   = $clog2(LANES + 1);

   if (LINE_W % WORD_W != 0 || LANES < 2) begin : g_bad_width
      $error("LINE_W must hold at least two whole WORD_W words");
   end

   logic [WCW-1:0]    fill_q;
   logic [ADDR_W-1:0] addr_q;
   logic              accept;

   assign line_full = (fill_q == WCW'(LANES));
   assign wr_ready  = !line_full;
   assign accept    = wr_valid && !line_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
         addr_q <= '0;
      end else begin
         if (flush)       fill_q <= '0;
         else if (accept) fill_q <= fill_q + 1'b1;
         if (accept && fill_q == '0) addr_q <= wr_line;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [WORD_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             lane_q <= '0;
         else if (accept && fill_q == WCW'(g))   lane_q <= wr_word;
      end
      assign line_data[g*WORD_W +: WORD_W] = lane_q;
   end

   assign line_addr = addr_q;
endmodule

// File: rtl/locmem_pf_seq.sv
module locmem_pf_seq #(
   parameter int ADDR_W = 14,
   parameter int IDX_W  = 2,
   parameter int PF_MIN = 17
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    branch,
   input  logic [ADDR_W+IDX_W-1:0] target,
   input  logic                    grant,
   output logic                    req,
   output logic [ADDR_W-1:0]       line_addr
);
   localparam int IPL   = 1 << IDX_W;
   localparam int MAXL  = (PF_MIN + 2 * IPL - 2) / IPL;
   localparam int CNTW  = $clog2(MAXL + 1);

   if (IDX_W < 1 || PF_MIN < 1) begin : g_bad_cfg
      $error("IDX_W and PF_MIN must be at least 1");
   end

   logic [ADDR_W-1:0] ptr_q;
   logic [CNTW-1:0]   left_q;
   logic [CNTW-1:0]   left_load;
   logic [IDX_W-1:0]  offset;

   assign offset    = target[IDX_W-1:0];
   assign left_load = CNTW'((32'(offset) + PF_MIN + IPL - 1) / IPL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         left_q <= '0;
      end else if (branch) begin
         ptr_q  <= target[ADDR_W+IDX_W-1:IDX_W];
         left_q <= left_load;
      end else if (grant) begin
         ptr_q  <= ptr_q + 1'b1;
         left_q <= left_q - 1'b1;
      end
   end

   assign req       = (left_q != '0);
   assign line_addr = ptr_q;
endmodule

// File: rtl/locmem_arbiter.sv
module locmem_arbiter
   import locmem_pkg::*;
#(
   parameter int ADDR_W       = 14,
   parameter int LINE_W       = 128,
   parameter int WORD_W       = 32,
   parameter int INSN_W       = 32,
   parameter int SLOT_PERIOD  = 8,
   parameter int PF_MIN       = 17,
   parameter bit DMA_WR_FIRST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    dma_rd_req,
   input  logic [ADDR_W-1:0]       dma_rd_addr,
   output logic                    dma_rd_gnt,
   input  logic                    dma_wr_valid,
   input  logic [ADDR_W-1:0]       dma_wr_line,
   input  logic [WORD_W-1:0]       dma_wr_word,
   output logic                    dma_wr_ready,
   input  logic                    ls_req,
   input  logic                    ls_we,
   input  logic [ADDR_W-1:0]       ls_addr,
   input  logic [LINE_W-1:0]       ls_wdata,
   output logic                    ls_gnt,
   input  logic                    pf_branch,
   input  logic [ADDR_W+$clog2(LINE_W/INSN_W)-1:0] pf_target,
   output logic                    pf_gnt,
   output logic                    pf_busy,
   output logic                    mem_en,
   output logic                    mem_we,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [LINE_W-1:0]       mem_wdata
);
   localparam int IPL   = LINE_W / INSN_W;
   localparam int IDX_W = $clog2(IPL);

   if (LINE_W % INSN_W != 0 || (IPL & (IPL - 1)) != 0) begin : g_bad_insn
      $error("LINE_W must hold a power-of-two count of instructions");
   end

   logic              slot_open;
   logic              line_full;
   logic [ADDR_W-1:0] acc_line;
   logic [LINE_W-1:0] acc_data;
   logic              pf_req;
   logic [ADDR_W-1:0] pf_line;
   logic              wr_gnt;
   gnt_e              dma_sel;
   gnt_e              gsel;

   locmem_slot_timer #(.SLOT_PERIOD(SLOT_PERIOD)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_open (slot_open)
   );

   locmem_dma_accum #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (dma_wr_valid),
      .wr_line   (dma_wr_line),
      .wr_word   (dma_wr_word),
      .flush     (wr_gnt),
      .wr_ready  (dma_wr_ready),
      .line_full (line_full),
      .line_addr (acc_line),
      .line_data (acc_data)
   );

   locmem_pf_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PF_MIN(PF_MIN)) u_pf (
      .clk       (clk),
      .rst_n     (rst_n),
      .branch    (pf_branch),
      .target    (pf_target),
      .grant     (pf_gnt),
      .req       (pf_req),
      .line_addr (pf_line)
   );

   if (DMA_WR_FIRST) begin : g_wr_first
      always_comb begin
         if (slot_open && line_full)       dma_sel = GNT_DMA_WR;
         else if (slot_open && dma_rd_req) dma_sel = GNT_DMA_RD;
         else                              dma_sel = GNT_NONE;
      end
   end else begin : g_rd_first
      always_comb begin
         if (slot_open && dma_rd_req)      dma_sel = GNT_DMA_RD;
         else if (slot_open && line_full)  dma_sel = GNT_DMA_WR;
         else                              dma_sel = GNT_NONE;
      end
   end

   always_comb begin
      gsel = dma_sel;
      if (gsel == GNT_NONE) begin
         if (ls_req)      gsel = GNT_LS;
         else if (pf_req) gsel = GNT_PF;
      end
   end

   assign wr_gnt     = (gsel == GNT_DMA_WR);
   assign dma_rd_gnt = (gsel == GNT_DMA_RD);
   assign ls_gnt     = (gsel == GNT_LS);
   assign pf_gnt     = (gsel == GNT_PF);
   assign pf_busy    = pf_req;

   always_comb begin
      mem_en    = (gsel != GNT_NONE);
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (gsel)
         GNT_DMA_WR: begin
            mem_we    = 1'b1;
            mem_addr  = acc_line;
            mem_wdata = acc_data;
         end
         GNT_DMA_RD: mem_addr = dma_rd_addr;
         GNT_LS: begin
            mem_we    = ls_we;
            mem_addr  = ls_addr;
            mem_wdata = ls_wdata;
         end
         GNT_PF:  mem_addr = pf_line;
         default: ;
      endcase
   end
endmodule

// File: rtl/locmem_arbiter_chk.sv
module locmem_arbiter_chk #(
   parameter int ADDR_W      = 14,
   parameter int SLOT_PERIOD = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_gnt,
   input logic              dma_rd_gnt,
   input logic              ls_gnt,
   input logic              pf_gnt,
   input logic              ls_req,
   input logic              pf_branch,
   input logic              mem_en,
   input logic              dma_wr_ready,
   input logic [ADDR_W-1:0] mem_addr
);
   localparam int GW = $clog2(SLOT_PERIOD + 1);

   logic              dma_any;
   logic              dma_seen;
   logic [GW-1:0]     gap_q;
   logic              pf_had;
   logic              pf_fresh;
   logic [ADDR_W-1:0] pf_last;

   assign dma_any = wr_gnt || dma_rd_gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_seen <= 1'b0;
         gap_q    <= '0;
         pf_had   <= 1'b0;
         pf_fresh <= 1'b0;
         pf_last  <= '0;
      end else begin
         if (dma_any) begin
            dma_seen <= 1'b1;
            gap_q    <= GW'(1);
         end else if (gap_q != GW'(SLOT_PERIOD)) begin
            gap_q <= gap_q + 1'b1;
         end
         if (pf_gnt) begin
            pf_had  <= 1'b1;
            pf_last <= mem_addr;
         end
         if (pf_branch)   pf_fresh <= 1'b1;
         else if (pf_gnt) pf_fresh <= 1'b0;
      end
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_gnt, dma_rd_gnt, ls_gnt, pf_gnt})); // R1
   AST_EN_MATCHES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en == (wr_gnt || dma_rd_gnt || ls_gnt || pf_gnt)); // R1
   AST_DMA_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_any && dma_seen) |-> (gap_q == GW'(SLOT_PERIOD))); // R2
   AST_LS_OVER_PF: assert property (@(posedge clk) disable iff (!rst_n)
      pf_gnt |-> !ls_req); // R4
   AST_LS_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      ls_req |-> mem_en); // R5
   AST_READY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_gnt |=> dma_wr_ready); // R6
   AST_PF_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_gnt && pf_had && !pf_fresh) |-> (mem_addr == pf_last + 1'b1)); // R7
endmodule

bind locmem_arbiter locmem_arbiter_chk #(.ADDR_W(ADDR_W), .SLOT_PERIOD(SLOT_PERIOD)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_gnt       (wr_gnt),
   .dma_rd_gnt   (dma_rd_gnt),
   .ls_gnt       (ls_gnt),
   .pf_gnt       (pf_gnt),
   .ls_req       (ls_req),
   .pf_branch    (pf_branch),
   .mem_en       (mem_en),
   .dma_wr_ready (dma_wr_ready),
   .mem_addr     (mem_addr)
);

// File: tb/locmem_arbiter_bench.sv
module locmem_arbiter_bench;
   localparam int AW = 14;
   localparam int LW = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dma_rd_req = 1'b0;
   logic [AW-1:0] dma_rd_addr = '0;
   logic          dma_rd_gnt;
   logic          dma_wr_valid = 1'b0;
   logic [AW-1:0] dma_wr_line = '0;
   logic [31:0]   dma_wr_word = '0;
   logic          dma_wr_ready;
   logic          ls_req = 1'b0;
   logic          ls_we = 1'b0;
   logic [AW-1:0] ls_addr = '0;
   logic [LW-1:0] ls_wdata = '0;
   logic          ls_gnt;
   logic          pf_branch = 1'b0;
   logic [AW+1:0] pf_target = '0;
   logic          pf_gnt;
   logic          pf_busy;
   logic          mem_en;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [LW-1:0] mem_wdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model, advanced once per cycle from the requirements
   int            ph = 0;
   int            mwords = 0;
   logic [AW-1:0] mline = '0;
   logic [LW-1:0] mbuf = '0;
   logic [AW-1:0] mptr = '0;
   int            mleft = 0;
   int            e_code, a_code, ngnt;
   logic [AW-1:0] e_addr;
   logic          e_we;

   always #10 clk = ~clk;

   locmem_arbiter u_locmem_arbiter (
      .clk(clk), .rst_n(rst_n),
      .dma_rd_req(dma_rd_req), .dma_rd_addr(dma_rd_addr), .dma_rd_gnt(dma_rd_gnt),
      .dma_wr_valid(dma_wr_valid), .dma_wr_line(dma_wr_line), .dma_wr_word(dma_wr_word),
      .dma_wr_ready(dma_wr_ready),
      .ls_req(ls_req), .ls_we(ls_we), .ls_addr(ls_addr), .ls_wdata(ls_wdata), .ls_gnt(ls_gnt),
      .pf_branch(pf_branch), .pf_target(pf_target), .pf_gnt(pf_gnt), .pf_busy(pf_busy),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [LW-1:0] act, input logic [LW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h (phase %0d)", tag, what, act, exp, ph);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   // grant codes: 0 none, 1 DMA write, 2 DMA read, 3 load/store, 4 prefetch, 7 several
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (ph == 0 && mwords == 4)       e_code = 1;
         else if (ph == 0 && dma_rd_req)   e_code = 2;
         else if (ls_req)                  e_code = 3;
         else if (mleft != 0)              e_code = 4;
         else                              e_code = 0;

         ngnt = int'(dma_rd_gnt) + int'(ls_gnt) + int'(pf_gnt);
         if (ngnt > 1)                            a_code = 7;
         else if (dma_rd_gnt)                     a_code = 2;
         else if (ls_gnt)                         a_code = 3;
         else if (pf_gnt)                         a_code = 4;
         else if (mem_en && mem_we)               a_code = 1;
         else if (mem_en)                         a_code = 7;
         else                                     a_code = 0;

         if ((a_code == 1 || a_code == 2) && ph != 0)
            chk(1'b0, "R2", "DMA grant outside slot", LW'(a_code), LW'(e_code));
         else if (ph == 0)
            chk(a_code == e_code, "R3", "slot grant", LW'(a_code), LW'(e_code));
         else
            chk(a_code == e_code, "R4", "grant", LW'(a_code), LW'(e_code));

         if (ls_req) chk(mem_en, "R5", "ls_req left idle", LW'(mem_en), LW'(1));

         e_addr = '0; e_we = 1'b0;
         case (e_code)
            1: begin e_addr = mline; e_we = 1'b1; end
            2: e_addr = dma_rd_addr;
            3: begin e_addr = ls_addr; e_we = ls_we; end
            4: e_addr = mptr;
            default: ;
         endcase
         if (e_code != 0) begin
            chk(mem_addr == e_addr, (e_code == 4) ? "R7" : "R1", "mem_addr", LW'(mem_addr), LW'(e_addr));
            chk(mem_we == e_we, "R1", "mem_we", LW'(mem_we), LW'(e_we));
         end
         if (e_code == 1) chk(mem_wdata == mbuf, "R6", "flushed line", mem_wdata, mbuf);
         if (e_code == 3 && ls_we) chk(mem_wdata == ls_wdata, "R1", "ls write data", mem_wdata, ls_wdata);
         chk(dma_wr_ready == (mwords != 4), "R6", "dma_wr_ready", LW'(dma_wr_ready), LW'(mwords != 4));
         chk(pf_busy == (mleft != 0), "R7", "pf_busy", LW'(pf_busy), LW'(mleft != 0));

         // advance the model to the next cycle
         if (e_code == 1) mwords = 0;
         else if (dma_wr_valid && mwords != 4) begin
            if (mwords == 0) mline = dma_wr_line;
            mbuf[mwords*32 +: 32] = dma_wr_word;
            mwords++;
         end
         if (pf_branch) begin
            mptr  = pf_target[AW+1:2];
            mleft = (int'(pf_target[1:0]) + 17 + 3) / 4;
         end else if (e_code == 4) begin
            mptr  = mptr + 1'b1;
            mleft = mleft - 1;
         end
         ph = (ph + 1) % 8;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL R5 watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R8: idle state right after reset
      @(negedge clk);
      chk(!mem_en && !dma_rd_gnt && !ls_gnt && !pf_gnt, "R8", "idle grants", LW'(mem_en), LW'(0));
      chk(dma_wr_ready && !pf_busy, "R8", "ready/busy", LW'({dma_wr_ready, pf_busy}), LW'(2'b10));
      step();

      // R2/R3/R4: DMA read against load/store across all slot phases
      for (int i = 0; i < 24; i++) begin
         dma_rd_req  = 1'b1;
         dma_rd_addr = AW'(14'h100 + i);
         ls_req      = 1'b1;
         ls_we       = i[0];
         ls_addr     = AW'(i * 3 + 5);
         ls_wdata    = {4{32'hC0DE_0000 + 32'(i)}};
         step();
      end
      dma_rd_req = 1'b0;

      // R4/R5: load/store alone owns every slot
      for (int i = 0; i < 8; i++) begin
         ls_addr = AW'(14'h2A0 + i);
         ls_we   = i[1];
         step();
      end
      ls_req = 1'b0;

      // R7: prefetch runs for every offset inside the target line
      for (int off = 0; off < 4; off++) begin
         pf_branch = 1'b1;
         pf_target = {AW'(14'h200 + off * 16), off[1:0]};
         step();
         pf_branch = 1'b0;
         for (int j = 0; j < 10; j++) begin
            ls_req  = (j % 3 == 0);
            ls_addr = AW'(14'h050 + j);
            step();
         end
         ls_req = 1'b0;
      end

      // R7: a branch in mid-run restarts the sequence
      pf_branch = 1'b1; pf_target = {AW'(14'h3F0), 2'd1}; step();
      pf_branch = 1'b0; step(); step();
      pf_branch = 1'b1; pf_target = {AW'(14'h111), 2'd3}; step();
      pf_branch = 1'b0;
      repeat (10) step();

      // R6/R3: staged DMA lines competing with DMA read, load/store and prefetch
      for (int ln = 0; ln < 3; ln++) begin
         for (int k = 0; k < 5; k++) begin
            dma_wr_valid = 1'b1;
            dma_wr_line  = (k == 0) ? AW'(14'h300 + ln) : AW'(14'h3AA);
            dma_wr_word  = 32'hD000_0000 + 32'(ln * 256 + k * 17);
            step();
         end
         dma_wr_valid = 1'b0;
         dma_rd_req   = (ln != 1);
         dma_rd_addr  = AW'(14'h1C0 + ln);
         pf_branch    = 1'b1;
         pf_target    = {AW'(14'h080 + ln), ln[1:0]};
         step();
         pf_branch = 1'b0;
         for (int j = 0; j < 20; j++) begin
            ls_req  = (j % 2 == 1);
            ls_we   = 1'b1;
            ls_addr = AW'(14'h060 + j);
            ls_wdata = {4{32'h5A5A_0000 + 32'(j)}};
            step();
         end
         ls_req = 1'b0;
         dma_rd_req = 1'b0;
      end

      repeat (4) step();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule